// File: doc/BRIEF.md
# Protection-Aware Memory Checksum Unit

This unit folds a 12-bit program memory image into a 16-bit checksum while the words stream past it. A `start_i` pulse clears the running total and samples the protection input. The unit then accepts words in a fixed order: all program words first, then one configuration word, then the identification words. A word is taken on any clock edge where `word_valid_i` is high, so the producer may leave idle cycles between words.

With protection off, each program word is added as stored. The configuration word contributes only its low nibble, and a fixed bias of 0x0FF0 is added, so a fully erased image gives 0x0DFF. With protection on, each program word is first reduced to the exclusive-or of its three nibbles. The configuration word is masked in the same way. The low nibbles of the identification words are packed into one 16-bit value, with the first identification word in the most significant nibble, and that value is added. Only the low 16 bits of the total are kept.

The unit sits between a memory reader and whatever consumes the checksum. `done_o` marks a final result and holds until the next start.

Top module: `ckmem_checksum`

## Requirements
- R1: After reset, `sum_o` is 0 and `done_o` is 0.
- R2: A `start_i` pulse makes `sum_o` 0 and `done_o` 0 on the next cycle. A word presented in the same cycle as `start_i` is not counted.
- R3: The total is kept modulo 2^16, and carries out of bit 15 are discarded. For example, 512 words of 0xFFF plus the other terms wrap to 0x0DFF.
- R4: With protection off, each of the 512 program words is added unchanged, the identification words add nothing, and 0x0FF0 is added once. An all-0xFFF image (program, configuration and identification words) yields 0x0DFF.
- R5: With protection on, each program word contributes bits[11:8] ^ bits[7:4] ^ bits[3:0]. Words 0x123 and 0x456 together contribute 0x0007.
- R6: In both modes the configuration word contributes only bits[3:0]. Configuration word 0xFF5 adds 5.
- R7: With protection on, identification word k (k = 0 to 3, in arrival order) adds its bits[3:0] shifted left by 4*(3-k). IDs 1, 2, 3, 4 add 0x1234.
- R8: Words are taken in this order: 512 program words, 1 configuration word, 4 identification words. `done_o` rises on the cycle after the last identification word is accepted and stays low before then.
- R9: Cycles with `word_valid_i` low accept no word and do not advance the sequence, so gaps do not change the result.
- R10: Once `done_o` is high, or after reset before any start, words are ignored. `sum_o` and `done_o` hold until the next `start_i`.
- R11: The protection mode is sampled at `start_i`. Changing `prot_i` during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the total and begins a new pass |
| prot_i | input | 1 | Protection mode, sampled at start |
| word_valid_i | input | 1 | The current word is valid |
| word_i | input | 12 | Memory word |
| sum_o | output | 16 | Running or final checksum |
| done_o | output | 1 | The checksum is final |

## Verification
Every result has a fixed latency. Clearing by start is visible one cycle after the start edge. Each accepted word enters the total on the edge that accepts it. The final sum and `done_o` appear on the cycle right after the edge that takes the last identification word. The bench drives inputs on the falling edge and reads outputs on the next falling edge. It checks that `done_o` is still low while the last word is presented, then checks `sum_o` and `done_o` exactly one cycle later. For ignored inputs, it checks that `sum_o` is held over several cycles of such stimulus and again before the next start.

// File: rtl/ckmem_pkg.sv
package ckmem_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PROG = 2'd1,
    PH_CFG  = 2'd2,
    PH_ID   = 2'd3
  } ck_phase_e;
endpackage

// File: rtl/ckmem_seq.sv
module ckmem_seq
  import ckmem_pkg::*;
#(
  parameter int PROG_WORDS = 512,
  parameter int ID_WORDS   = 4,
  parameter int CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             prot_i,
  input  logic             valid_i,
  output ck_phase_e        phase_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             prot_o,
  output logic             accept_o,
  output logic             last_o
);
  ck_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             prot_q;
  logic             prog_end, id_end;

  assign prog_end = (cnt_q == CNT_W'(PROG_WORDS - 1));
  assign id_end   = (cnt_q == CNT_W'(ID_WORDS - 1));
  assign accept_o = valid_i && !start_i && (phase_q != PH_IDLE);
  assign last_o   = accept_o && (phase_q == PH_ID) && id_end;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      phase_d = PH_PROG;
      cnt_d   = '0;
    end else if (accept_o) begin
      unique case (phase_q)
        PH_PROG: begin
          if (prog_end) begin
            phase_d = PH_CFG;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_CFG: begin
          phase_d = PH_ID;
          cnt_d   = '0;
        end
        PH_ID: begin
          if (id_end) begin
            phase_d = PH_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      prot_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (start_i) prot_q <= prot_i;
    end
  end

  assign phase_o = phase_q;
  assign idx_o   = cnt_q;
  assign prot_o  = prot_q;
endmodule

// File: rtl/ckmem_xform.sv
module ckmem_xform
  import ckmem_pkg::*;
#(
  parameter int              WORD_W   = 12,
  parameter int              SUM_W    = 16,
  parameter int              ID_WORDS = 4,
  parameter int              CNT_W    = 10,
  parameter logic [WORD_W-1:0] CFG_MASK = 12'h00F,
  parameter logic [SUM_W-1:0]  OFF_BIAS = 16'h0FF0
) (
  input  ck_phase_e         phase_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic              prot_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [SUM_W-1:0]  addend_o
);
  localparam int NIBS = WORD_W / 4;

  logic [3:0] nib_acc [NIBS+1];

  assign nib_acc[0] = 4'h0;
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    assign nib_acc[g+1] = nib_acc[g] ^ word_i[4*g +: 4];
  end

  logic [SUM_W-1:0] raw_ext, red_ext, cfg_ext, nib_ext, id_term;
  int unsigned      shamt;

  assign raw_ext = SUM_W'(word_i);
  assign red_ext = SUM_W'(nib_acc[NIBS]);
  assign cfg_ext = SUM_W'(word_i & CFG_MASK);
  assign nib_ext = SUM_W'(word_i[3:0]);

  always_comb begin
    shamt   = 4 * (ID_WORDS - 1 - int'(idx_i));
    id_term = nib_ext << shamt;
  end

  always_comb begin
    unique case (phase_i)
      PH_PROG: addend_o = prot_i ? red_ext : raw_ext;
      PH_CFG:  addend_o = prot_i ? cfg_ext : cfg_ext + OFF_BIAS;
      PH_ID:   addend_o = prot_i ? id_term : '0;
      default: addend_o = '0;
    endcase
  end
endmodule

// File: rtl/ckmem_acc.sv
module ckmem_acc #(
  parameter int SUM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             add_i,
  input  logic             last_i,
  input  logic [SUM_W-1:0] addend_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             done_o
);
  logic [SUM_W-1:0] sum_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q  <= '0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      sum_q  <= '0;
      done_q <= 1'b0;
    end else if (add_i) begin
      sum_q  <= sum_q + addend_i;  // wraps modulo 2^SUM_W
      done_q <= last_i;
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;
endmodule

// File: rtl/ckmem_checksum.sv
module ckmem_checksum
  import ckmem_pkg::*;
#(
  parameter int                WORD_W     = 12,
  parameter int                SUM_W      = 16,
  parameter int                PROG_WORDS = 512,
  parameter int                ID_WORDS   = 4,
  parameter logic [WORD_W-1:0] CFG_MASK   = 12'h00F,
  parameter logic [SUM_W-1:0]  OFF_BIAS   = 16'h0FF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              prot_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              done_o
);
  localparam int MAX_CNT = (PROG_WORDS > ID_WORDS) ? PROG_WORDS : ID_WORDS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  ck_phase_e        phase_w;
  logic [CNT_W-1:0] idx_w;
  logic             prot_w, accept_w, last_w, busy_w;
  logic [SUM_W-1:0] addend_w;

  ckmem_seq #(
    .PROG_WORDS(PROG_WORDS), .ID_WORDS(ID_WORDS), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .prot_i(prot_i),
    .valid_i(word_valid_i), .phase_o(phase_w), .idx_o(idx_w),
    .prot_o(prot_w), .accept_o(accept_w), .last_o(last_w)
  );

  ckmem_xform #(
    .WORD_W(WORD_W), .SUM_W(SUM_W), .ID_WORDS(ID_WORDS), .CNT_W(CNT_W),
    .CFG_MASK(CFG_MASK), .OFF_BIAS(OFF_BIAS)
  ) u_xform (
    .phase_i(phase_w), .idx_i(idx_w), .prot_i(prot_w),
    .word_i(word_i), .addend_o(addend_w)
  );

  ckmem_acc #(.SUM_W(SUM_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i), .add_i(accept_w),
    .last_i(last_w), .addend_i(addend_w), .sum_o(sum_o), .done_o(done_o)
  );

  assign busy_w = (phase_w != PH_IDLE);
endmodule

// File: rtl/ckmem_checksum_chk.sv
module ckmem_checksum_chk #(
  parameter int SUM_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             accept_w,
  input logic             last_w,
  input logic             busy_w,
  input logic [SUM_W-1:0] sum_o,
  input logic             done_o
);
  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sum_o == '0) && !done_o);

  p_done_after_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_w && last_w) |=> done_o);

  p_done_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(accept_w && last_w));

  p_no_done_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_w |-> !done_o);

  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_w && !start_i) |=> $stable(sum_o));

  p_done_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

bind ckmem_checksum ckmem_checksum_chk #(.SUM_W(SUM_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .accept_w(accept_w),
  .last_w(last_w), .busy_w(busy_w), .sum_o(sum_o), .done_o(done_o)
);

// File: tb/sim_ckmem_checksum.sv
`timescale 1ns/1ps
module sim_ckmem_checksum;
  localparam int NPROG = 512;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        prot_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [11:0] word_i = '0;
  logic [15:0] sum_o;
  logic        done_o;

  int total = 0;
  int bad = 0;

  logic [11:0] img [NPROG];
  logic [11:0] cfg;
  logic [11:0] ids [4];

  always #10 clk_i = ~clk_i;

  ckmem_checksum u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .prot_i(prot_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .sum_o(sum_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic p);
    logic [15:0] s = '0;
    for (int i = 0; i < NPROG; i++)
      s += p ? 16'(img[i][11:8] ^ img[i][7:4] ^ img[i][3:0]) : 16'(img[i]);
    s += 16'(cfg & 12'h00F);
    if (!p) s += 16'h0FF0;
    else for (int k = 0; k < 4; k++) s += 16'(ids[k][3:0]) << (4 * (3 - k));
    return s;
  endfunction

  // drive a full pass; inputs change on falling edges
  task automatic run(input logic p_start, input logic p_mid, input bit gaps,
                     input bit start_word, input logic [15:0] exp, input string req);
    logic [11:0] seq_w [NPROG + 5];
    for (int i = 0; i < NPROG; i++) seq_w[i] = img[i];
    seq_w[NPROG] = cfg;
    for (int k = 0; k < 4; k++) seq_w[NPROG + 1 + k] = ids[k];
    @(negedge clk_i);
    start_i = 1'b1; prot_i = p_start;
    word_valid_i = start_word; word_i = 12'hFFF;
    @(negedge clk_i);
    start_i = 1'b0; word_valid_i = 1'b0;
    check("R2 sum cleared", sum_o, 16'h0000);
    check("R2 done cleared", {15'd0, done_o}, 16'd0);
    prot_i = p_mid;
    for (int i = 0; i < NPROG + 5; i++) begin
      if (gaps && (i % 3 == 0)) begin
        word_valid_i = 1'b0; word_i = 12'hABC;
        @(negedge clk_i);
      end
      word_valid_i = 1'b1; word_i = seq_w[i];
      if (i == NPROG + 4) check("R8 done low before last", {15'd0, done_o}, 16'd0);
      @(negedge clk_i);
    end
    word_valid_i = 1'b0;
    check({req, " sum"}, sum_o, exp);
    check("R8 done one cycle after last", {15'd0, done_o}, 16'd1);
  endtask

  task automatic t_reset;
    check("R1 sum reset", sum_o, 16'h0000);
    check("R1 done reset", {15'd0, done_o}, 16'd0);
    // R10: words before any start are ignored
    word_valid_i = 1'b1; word_i = 12'h777;
    repeat (3) @(negedge clk_i);
    word_valid_i = 1'b0;
    check("R10 idle words ignored", sum_o, 16'h0000);
  endtask

  task automatic t_blank_off;
    for (int i = 0; i < NPROG; i++) img[i] = 12'hFFF;
    cfg = 12'hFFF;
    for (int k = 0; k < 4; k++) ids[k] = 12'hFFF;
    run(1'b0, 1'b0, 1'b0, 1'b0, 16'h0DFF, "R4 R3 blank off");
  endtask

  task automatic t_blank_on;
    run(1'b1, 1'b1, 1'b0, 1'b0, 16'h1E0E, "R5 blank on");
  endtask

  task automatic t_pattern_gaps;
    for (int i = 0; i < NPROG; i++) img[i] = 12'((i * 37 + 5) & 12'hFFF);
    cfg = 12'h9A3;
    for (int k = 0; k < 4; k++) ids[k] = 12'(12'h150 + k * 7);
    run(1'b0, 1'b0, 1'b1, 1'b0, model(1'b0), "R9 gaps off");
    run(1'b1, 1'b1, 1'b1, 1'b0, model(1'b1), "R9 gaps on");
  endtask

  task automatic t_example_on;
    for (int i = 0; i < NPROG; i++) img[i] = 12'h000;
    img[0] = 12'h123; img[1] = 12'h456;
    cfg = 12'hFF5;
    ids[0] = 12'hF01; ids[1] = 12'h002; ids[2] = 12'hA03; ids[3] = 12'h004;
    run(1'b1, 1'b1, 1'b0, 1'b0, 16'h1240, "R5 R6 R7 example");
    run(1'b0, 1'b0, 1'b0, 1'b0, 16'h0579 + 16'h0005 + 16'h0FF0, "R6 R4 example off");
  endtask

  task automatic t_prot_mid;
    for (int i = 0; i < NPROG; i++) img[i] = 12'((i * 91 + 3) & 12'hFFF);
    cfg = 12'h12C;
    for (int k = 0; k < 4; k++) ids[k] = 12'(12'h30A + k);
    run(1'b1, 1'b0, 1'b0, 1'b0, model(1'b1), "R11 prot sampled at start on");
    run(1'b0, 1'b1, 1'b0, 1'b0, model(1'b0), "R11 prot sampled at start off");
  endtask

  task automatic t_after_done;
    logic [15:0] held;
    held = sum_o;
    word_valid_i = 1'b1; word_i = 12'h5A5;
    repeat (6) @(negedge clk_i);
    word_valid_i = 1'b0;
    check("R10 sum held after done", sum_o, held);
    check("R10 done held", {15'd0, done_o}, 16'd1);
  endtask

  task automatic t_start_word;
    for (int i = 0; i < NPROG; i++) img[i] = 12'hFFF;
    img[7] = 12'h001;
    cfg = 12'h0F0;
    for (int k = 0; k < 4; k++) ids[k] = 12'hFFF;
    run(1'b0, 1'b0, 1'b0, 1'b1, model(1'b0), "R2 start word dropped R3");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_blank_off();
        t_blank_on();
        t_pattern_gaps();
        t_example_on();
        t_after_done();
        t_prot_mid();
        t_start_word();
      end
      begin
        repeat (100000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule